// File: doc/BRIEF.md
# Four-Channel Sample Frame Read Port

This block sits between four 16-bit converter channels and the asynchronous external memory bus of a signal processor. On each conversion period a shared sample strobe stores one frame, made of one sample from each channel, into a small frame FIFO. The processor, usually through its DMA engine, reads the frame back as four 16-bit words from four consecutive bus addresses, so the whole frame moves in a single four-word burst. The bus is only 16 bits wide, so the four words of a frame always come one after another.

The strobes arrive without a clock relationship to the block. They pass through two-stage synchronisers, and a word leaves the FIFO only when the output-enable strobe goes inactive. A build parameter selects the window decode. In the streaming variant the two low address bits are ignored, and every read steps to the next word in channel order, so a reader can also use one fixed address. In the slot variant each address returns one fixed channel, and the frame is retired only when the channel-3 slot is read. This allows a single channel to be sampled without disturbing the frame. A ready output can trigger the DMA event. A status word holds sticky overflow and underflow flags.

Top module: `adc_frame_port`

## Requirements
- R1: A rising edge of `smp_stb` stores the four channel values on `smp_data` as one frame. Channel k occupies bits [16k+15:16k].
- R2: With `FULL_DECODE`=0, reads at addresses 0 to 3 ignore `bus_addr[1:0]`. Successive reads return channel 0, 1, 2, 3 of the oldest frame, even when every read uses the same fixed address. The frame is retired after its fourth word.
- R3: With `FULL_DECODE`=1, a read at address k (0 to 3) returns channel k of the oldest frame. Only a read at address 3 retires the frame. Reads at addresses 0 to 2 leave it in place.
- R4: Read data is on `bus_dout`, with `bus_dout_en` high, by the fourth rising clock edge after `bus_cs_n` and `bus_oe_n` both go low. When no read is in progress, `bus_dout` is 0 and `bus_dout_en` is low.
- R5: `frame_rdy` is high exactly while at least one complete frame is stored.
- R6: A frame that arrives while `DEPTH` frames are stored is discarded, and the sticky overflow flag (status bit 0) is set.
- R7: A data read while the FIFO is empty returns 0x0000 and sets the sticky underflow flag (status bit 1). The read position does not move, so the next frame written is returned intact from its first word.
- R8: A read at address 4 returns the status word {13'b0, frame_rdy (bit 2), underflow (bit 1), overflow (bit 0)}. At the end of that read both sticky flags are cleared.
- R9: The FIFO pops when `bus_oe_n` goes inactive and not earlier. While a read that will retire the last frame is still held, `frame_rdy` stays high.
- R10: Up to `DEPTH` frames are held, and they are returned in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| smp_stb | input | 1 | Asynchronous sample strobe; a rising edge captures a frame |
| smp_data | input | 64 | Four 16-bit channel samples, channel 0 in the low bits |
| bus_cs_n | input | 1 | Asynchronous chip select, active low |
| bus_oe_n | input | 1 | Asynchronous output enable, active low |
| bus_addr | input | 3 | Word address in the window: 0 to 3 data, 4 status |
| bus_dout | output | 16 | Read data |
| bus_dout_en | output | 1 | High while read data is being driven |
| frame_rdy | output | 1 | At least one complete frame stored |

## Verification
The hardest cases to reach from the ports involve states that build up over time. One is the moment the FIFO is already full when one more strobe arrives. Another is a read of an empty FIFO followed directly by a fresh frame, which shows whether the read position slipped. Directed sequences fill the FIFO one frame past capacity, read the status word to clear the flags, and read from an empty FIFO before refilling it. After that, seeded random mixes of captures and reads at all five addresses drive both decode variants side by side from the same bus. Each variant is checked against its own reference model.

// File: rtl/adc_frame_port.sv
module adc_frame_port #(
  parameter int DEPTH       = 8,
  parameter bit FULL_DECODE = 1'b0,
  parameter int SW          = 16,
  parameter int AW          = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_stb,
  input  logic [4*SW-1:0] smp_data,
  input  logic            bus_cs_n,
  input  logic            bus_oe_n,
  input  logic [AW-1:0]   bus_addr,
  output logic [SW-1:0]   bus_dout,
  output logic            bus_dout_en,
  output logic            frame_rdy
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = 4 * SW;

  logic [FW-1:0] mem [DEPTH];
  logic [PW:0]   wr_ptr, rd_ptr, cnt;
  logic [2:0]    stb_sh, oe_sh, cs_sh;
  logic          rd_act, ovf, udf;
  logic [1:0]    widx;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb_sh <= '0;
      oe_sh  <= '1;
      cs_sh  <= '1;
    end else begin
      stb_sh <= {stb_sh[1:0], smp_stb};
      oe_sh  <= {oe_sh[1:0], bus_oe_n};
      cs_sh  <= {cs_sh[1:0], bus_cs_n};
    end

  wire stb_rise = stb_sh[1] & ~stb_sh[2];
  wire rd_on    = ~cs_sh[1] & ~oe_sh[1];
  wire rd_end   = rd_act & ~rd_on;

  assign cnt       = wr_ptr - rd_ptr;
  wire   empty     = (cnt == 0);
  wire   full      = (cnt == (PW+1)'(DEPTH));
  assign frame_rdy = ~empty;

  wire [FW-1:0] head    = mem[rd_ptr[PW-1:0]];
  wire [1:0]    slot    = FULL_DECODE ? bus_addr[1:0] : widx;
  wire          is_data = ~bus_addr[2];
  wire          is_stat = bus_addr[2] & (bus_addr[1:0] == 2'd0);
  wire [SW-1:0] stat    = {{(SW-3){1'b0}}, frame_rdy, udf, ovf};
  wire [SW-1:0] dword   = empty ? '0 : head[int'(slot)*SW +: SW];
  wire [SW-1:0] rd_word = is_data ? dword : (is_stat ? stat : '0);

  wire data_q  = ~addr_q[2];
  wire stat_q  = addr_q[2] & (addr_q[1:0] == 2'd0);
  wire last_wd = FULL_DECODE ? (addr_q[1:0] == 2'd3) : (widx == 2'd3);
  wire d_end   = rd_end & data_q;
  wire retire  = d_end & ~empty & last_wd;
  wire accept  = stb_rise & ~full;

  always_ff @(posedge clk) if (accept) mem[wr_ptr[PW-1:0]] <= smp_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; widx <= '0;
      rd_act <= 1'b0; addr_q <= '0;
      ovf <= 1'b0; udf <= 1'b0;
      bus_dout <= '0; bus_dout_en <= 1'b0;
    end else begin
      rd_act      <= rd_on;
      bus_dout    <= rd_on ? rd_word : '0;
      bus_dout_en <= rd_on;
      if (rd_on && !rd_act) addr_q <= bus_addr;
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (retire) rd_ptr <= rd_ptr + 1'b1;
      if (!FULL_DECODE && d_end && !empty) widx <= widx + 1'b1;
      if (stb_rise && full)    ovf <= 1'b1;
      else if (rd_end && stat_q) ovf <= 1'b0;
      if (d_end && empty)      udf <= 1'b1;
      else if (rd_end && stat_q) udf <= 1'b0;
    end

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));
  assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_end && empty) |=> (rd_ptr == $past(rd_ptr)) && (widx == $past(widx)) && udf);
  assert_drop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && full) |=> (wr_ptr == $past(wr_ptr)) && ovf);
  assert_keep_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (FULL_DECODE && d_end && addr_q[1:0] != 2'd3) |=> rd_ptr == $past(rd_ptr));
  assert_pop_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_on |=> rd_ptr == $past(rd_ptr));
endmodule

// File: tb/adc_frame_port_test.sv
module adc_frame_port_test;
  localparam int D = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_stb = 1'b0, cs_n = 1'b1, oe_n = 1'b1;
  logic [63:0] smp_data = '0;
  logic [2:0]  addr = '0;
  logic [15:0] dout_s, dout_f;
  logic en_s, en_f, rdy_s, rdy_f;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  adc_frame_port #(.DEPTH(D), .FULL_DECODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_addr(addr),
    .bus_dout(dout_s), .bus_dout_en(en_s), .frame_rdy(rdy_s));
  adc_frame_port #(.DEPTH(D), .FULL_DECODE(1'b1)) uut_fd (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_addr(addr),
    .bus_dout(dout_f), .bus_dout_en(en_f), .frame_rdy(rdy_f));

  logic [63:0] qs[$], qf[$];
  int  widx_s = 0;
  bit  ovf_s = 0, udf_s = 0, ovf_f = 0, udf_f = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_s(logic [2:0] a);
    if (a == 3'd4) return {13'b0, qs.size() != 0, udf_s, ovf_s};
    if (a[2]) return 16'h0;
    if (qs.size() == 0) return 16'h0;
    return qs[0][16*widx_s +: 16];
  endfunction

  function automatic logic [15:0] exp_f(logic [2:0] a);
    if (a == 3'd4) return {13'b0, qf.size() != 0, udf_f, ovf_f};
    if (a[2]) return 16'h0;
    if (qf.size() == 0) return 16'h0;
    return qf[0][16*a[1:0] +: 16];
  endfunction

  task automatic capture(logic [63:0] f);
    @(negedge clk);
    smp_data = f; smp_stb = 1'b1;
    repeat (4) @(negedge clk);
    smp_stb = 1'b0;
    repeat (4) @(negedge clk);
    if (qs.size() < D) qs.push_back(f); else ovf_s = 1;
    if (qf.size() < D) qf.push_back(f); else ovf_f = 1;
    chk("R1/R5 rdy simple", 16'(rdy_s), 16'(qs.size() != 0));
    chk("R1/R5 rdy slot", 16'(rdy_f), 16'(qf.size() != 0));
  endtask

  task automatic rd(logic [2:0] a, string req);
    @(negedge clk);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({req, " simple data"}, dout_s, exp_s(a));
    chk({req, " slot data"}, dout_f, exp_f(a));
    chk("R4 dout_en", {14'b0, en_s, en_f}, 16'h3);
    chk("R9 rdy held", {14'b0, rdy_s, rdy_f}, {14'b0, qs.size() != 0, qf.size() != 0});
    oe_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    if (a == 3'd4) begin ovf_s = 0; udf_s = 0; end
    else if (!a[2]) begin
      if (qs.size() == 0) udf_s = 1;
      else if (widx_s == 3) begin void'(qs.pop_front()); widx_s = 0; end
      else widx_s++;
    end
    if (a == 3'd4) begin ovf_f = 0; udf_f = 0; end
    else if (!a[2]) begin
      if (qf.size() == 0) udf_f = 1;
      else if (a[1:0] == 2'd3) void'(qf.pop_front());
    end
    chk("R4 idle bus", {dout_s | dout_f}, 16'h0);
    chk("R5 rdy", {14'b0, rdy_s, rdy_f}, {14'b0, qs.size() != 0, qf.size() != 0});
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset dout", dout_s | dout_f, 16'h0);
    chk("R5 reset rdy", {14'b0, rdy_s, rdy_f}, 16'h0);
    // R7 empty read then R8 status clear
    rd(3'd0, "R7 empty");
    rd(3'd4, "R8 status udf");
    rd(3'd4, "R8 status cleared");
    capture(64'h3333_2222_1111_0000);
    // R2 fixed address, R3 slot stays
    for (int i = 0; i < 3; i++) rd(3'd2, "R2/R3 fixed addr");
    rd(3'd1, "R2/R3");
    rd(3'd3, "R3 retire");
    rd(3'd4, "R8 status after drain");
    // R6 overflow and R10 order
    for (int i = 0; i <= D; i++) capture({4{16'(16'hA000 + i)}} ^ 64'h0003_0002_0001_0000);
    rd(3'd4, "R6 R8 overflow status");
    for (int i = 0; i < D; i++) begin
      for (int k = 0; k < 4; k++) rd(3'(k), "R10 drain");
    end
    rd(3'd4, "R8 status empty");
    rd(3'd1, "R7 empty again");
    capture(64'h4444_5555_6666_7777);
    for (int k = 0; k < 4; k++) rd(3'(k), "R7 pointer intact");
    for (int n = 0; n < 150; n++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 3) capture({$urandom, $urandom});
      else rd(3'($urandom_range(0, 4)), "R2/R3 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule